// File: doc/BRIEF.md
# SD card power-cycle sequencer

This block performs a controlled power cycle of a removable SD card before any card initialisation takes place. It owns the card-side pins through open-drain style low enables for the clock, command and four data lines. It also drives a power-switch control and a gate that lets an external data clock through. From the pins it samples the pulled-up command and data levels, the clock-pin level (this stands in for a supply comparator) and a switch/card-detect level.

A single-cycle `start` launches a run. The block first returns every pin to a defined released state in a fixed order. It then pulses the command and data lines low and lets the pull-ups recover. What happens next depends on `sw_fitted`. Without a power switch, the run only confirms that the pull-ups are present. With a switch, it checks that a card is inserted, forces every line low, removes power for a blind interval, releases everything in the same fixed order and waits for the card supply to settle. The result stays on `done`, `ok`, `err_code` and `warn` until the next run.

All intervals are derived at elaboration from the clock frequency and from the requested durations in nanoseconds and microseconds.

Top module: `sd_pwr_seq`

## Requirements
- R1: While reset is asserted and after it, until the first start, every low enable and `pwr_off` are 0, `done`, `ok`, `err_code` and `warn` are 0, and `sclk_run_en` is 1.
- R2: An accepted start drops `sclk_run_en` in the first cycle while nothing is driven. After the opening release, CMD and all four DAT enables are driven for S cycles and then released for S cycles, and the clock enable is not driven during this pulse.
- R3: With `sw_fitted`=0, the run ends with `done`=1 exactly 4S+4 cycles after the start edge. It ends with `ok`=1 and `err_code`=0 only if `cmd_in`=1 and `dat_in`=4'b1111; otherwise it ends with `ok`=0 and `err_code`=1 (pull-ups missing). `det_in` and `sclk_in` are ignored.
- R4: With `sw_fitted`=1 and `det_in`=1 (no card), the run ends after 4S+4 cycles with `ok`=0 and `err_code`=2, and `pwr_off` never rises.
- R5: With `sw_fitted`=1 and `det_in`=0, one cycle drives CLK, CMD and DAT low with `pwr_off`=0. Then `pwr_off`=1 is held for P cycles with all lines still driven low.
- R6: Every release runs in this order: the clock gate is already off and lines stay as they were for one cycle; CMD and DAT are released for S cycles; the CLK enable is released for one cycle; then `pwr_off` drops, followed by S cycles of settling.
- R7: After the second release, the block waits W cycles. It then reports `done`=1, `ok`=1, `err_code`=0 exactly 6S+P+W+7 cycles after the start edge, and re-enables `sclk_run_en`.
- R8: `warn` is set to the `sclk_in` level seen in the last power-off cycle. A warning does not change `ok` or `err_code`.
- R9: A start while a run is in progress is ignored; the run's timing and result are unchanged.
- R10: `done` clears in the cycle after an accepted start, and all status outputs hold their value between runs.
- R11: S = max(1, (CLK_FREQ_HZ/1e6)·SETTLE_NS/1000), W = max(1, (CLK_FREQ_HZ/1e6)·PWRUP_US), P = max(1, (CLK_FREQ_HZ/1e6)·PWROFF_US).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Single-cycle request to run a power cycle |
| sw_fitted | input | 1 | 1 when a card power switch is present |
| sclk_in | input | 1 | Sampled level of the card clock pin (supply-referenced) |
| cmd_in | input | 1 | Sampled level of the command pin |
| dat_in | input | 4 | Sampled levels of the data pins |
| det_in | input | 1 | Switch/card-detect level; 1 means no card |
| sclk_run_en | output | 1 | 1 lets the external data clock reach the pin |
| sclk_drv_lo | output | 1 | 1 drives the clock pin low |
| cmd_drv_lo | output | 1 | 1 drives the command pin low |
| dat_drv_lo | output | 4 | 1 per bit drives that data pin low |
| pwr_off | output | 1 | 1 switches card power off |
| done | output | 1 | Run finished, holds until next start |
| ok | output | 1 | Run finished without error |
| err_code | output | 2 | 0 none, 1 pull-ups missing, 2 no card |
| warn | output | 1 | Clock level stayed high at the end of power-off |

## Verification
The bench sweeps every command/data level combination without a switch. A wrong pull-up decode would pass a board with one floating data line, or fail a good one. No-card runs check that power is never removed; a design that skipped the detect check would cut power to an empty slot. Full power cycles are compared cycle by cycle against the release order, so releasing power before the clock line, or the clock line before CMD/DAT, shows up as a pin mismatch. A supply model that does or does not decay confirms that `warn` follows the last off-cycle level without failing the run. A start injected mid-run confirms that a design which restarted on it would shift `done`.

// File: rtl/sd_pwr_pkg.sv
package sd_pwr_pkg;

  localparam int DAT_W = 4;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_REL_STOP,
    ST_REL_FLOAT,
    ST_REL_CLK,
    ST_REL_PWR,
    ST_PULSE_LO,
    ST_PULSE_REL,
    ST_CHECK,
    ST_DISCH,
    ST_OFF,
    ST_WAKE
  } seq_state_e;

  typedef enum logic [1:0] {
    ERR_NONE   = 2'd0,
    ERR_PULLUP = 2'd1,
    ERR_NOCARD = 2'd2
  } seq_err_e;

  typedef struct packed {
    logic             run_en;
    logic             pwr_off;
    logic             clk_lo;
    logic             cmd_lo;
    logic [DAT_W-1:0] dat_lo;
  } pin_ctl_t;

endpackage

// File: rtl/sd_pwr_timer.sv
module sd_pwr_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (load) begin
      cnt_d  = load_val;
      cnt_en = 1'b1;
    end else if (cnt_q != '0) begin
      cnt_d  = cnt_q - 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/sd_pwr_fsm.sv
module sd_pwr_fsm
  import sd_pwr_pkg::*;
#(
  parameter int CW    = 8,
  parameter int S_CYC = 1,
  parameter int P_CYC = 1,
  parameter int W_CYC = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             sw_fitted,
  input  logic             cmd_in,
  input  logic [DAT_W-1:0] dat_in,
  input  logic             det_in,
  input  logic             tmr_zero,
  output seq_state_e       state_q,
  output logic             pass2_q,
  output logic             tmr_load,
  output logic [CW-1:0]    tmr_val,
  output logic             accept,
  output logic             fin_set,
  output logic             fin_ok,
  output seq_err_e         fin_err,
  output logic             warn_load
);

  localparam logic [CW-1:0] S_LD = CW'(S_CYC - 1);
  localparam logic [CW-1:0] P_LD = CW'(P_CYC - 1);
  localparam logic [CW-1:0] W_LD = CW'(W_CYC - 1);

  seq_state_e st_d;
  logic       pass2_d;
  logic       st_en;
  logic       pass_en;

  // Count loaded on entry to a state: its length minus one.
  function automatic logic [CW-1:0] load_for(input seq_state_e s);
    case (s)
      ST_REL_FLOAT, ST_REL_PWR, ST_PULSE_LO, ST_PULSE_REL: load_for = S_LD;
      ST_OFF:  load_for = P_LD;
      ST_WAKE: load_for = W_LD;
      default: load_for = '0;
    endcase
  endfunction

  always_comb begin
    st_d      = state_q;
    pass2_d   = pass2_q;
    accept    = 1'b0;
    fin_set   = 1'b0;
    fin_ok    = 1'b0;
    fin_err   = ERR_NONE;
    warn_load = 1'b0;
    if (state_q == ST_IDLE) begin
      if (start) begin
        accept  = 1'b1;
        st_d    = ST_REL_STOP;
        pass2_d = 1'b0;
      end
    end else if (tmr_zero) begin
      case (state_q)
        ST_REL_STOP:  st_d = ST_REL_FLOAT;
        ST_REL_FLOAT: st_d = ST_REL_CLK;
        ST_REL_CLK:   st_d = ST_REL_PWR;
        ST_REL_PWR:   st_d = pass2_q ? ST_WAKE : ST_PULSE_LO;
        ST_PULSE_LO:  st_d = ST_PULSE_REL;
        ST_PULSE_REL: st_d = ST_CHECK;
        ST_CHECK: begin
          if (!sw_fitted) begin
            fin_set = 1'b1;
            st_d    = ST_IDLE;
            if (cmd_in && (&dat_in)) fin_ok = 1'b1;
            else                     fin_err = ERR_PULLUP;
          end else if (det_in) begin
            fin_set = 1'b1;
            fin_err = ERR_NOCARD;
            st_d    = ST_IDLE;
          end else begin
            st_d    = ST_DISCH;
            pass2_d = 1'b1;
          end
        end
        ST_DISCH: st_d = ST_OFF;
        ST_OFF: begin
          warn_load = 1'b1;
          st_d      = ST_REL_STOP;
        end
        ST_WAKE: begin
          fin_set = 1'b1;
          fin_ok  = 1'b1;
          st_d    = ST_IDLE;
        end
        default: st_d = ST_IDLE;
      endcase
    end
    st_en    = (st_d != state_q);
    pass_en  = (pass2_d != pass2_q);
    tmr_load = st_en;
    tmr_val  = load_for(st_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pass2_q <= 1'b0;
    end else begin
      if (st_en)   state_q <= st_d;
      if (pass_en) pass2_q <= pass2_d;
    end
  end

endmodule

// File: rtl/sd_pwr_pins.sv
module sd_pwr_pins
  import sd_pwr_pkg::*;
(
  input  seq_state_e state_q,
  input  logic       pass2_q,
  output pin_ctl_t   pins
);

  always_comb begin
    pins = '0;
    case (state_q)
      ST_IDLE: pins.run_en = 1'b1;
      ST_REL_STOP: begin
        pins.clk_lo  = pass2_q;
        pins.cmd_lo  = pass2_q;
        pins.dat_lo  = {DAT_W{pass2_q}};
        pins.pwr_off = pass2_q;
      end
      ST_REL_FLOAT: begin
        pins.clk_lo  = pass2_q;
        pins.pwr_off = pass2_q;
      end
      ST_REL_CLK: pins.pwr_off = pass2_q;
      ST_PULSE_LO: begin
        pins.cmd_lo = 1'b1;
        pins.dat_lo = '1;
      end
      ST_DISCH: begin
        pins.clk_lo = 1'b1;
        pins.cmd_lo = 1'b1;
        pins.dat_lo = '1;
      end
      ST_OFF: begin
        pins.clk_lo  = 1'b1;
        pins.cmd_lo  = 1'b1;
        pins.dat_lo  = '1;
        pins.pwr_off = 1'b1;
      end
      default: pins = '0;
    endcase
  end

endmodule

// File: rtl/sd_pwr_status.sv
module sd_pwr_status
  import sd_pwr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       fin_set,
  input  logic       fin_ok,
  input  seq_err_e   fin_err,
  input  logic       warn_load,
  input  logic       warn_val,
  output logic       done_q,
  output logic       ok_q,
  output logic [1:0] err_q,
  output logic       warn_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      ok_q   <= 1'b0;
      err_q  <= 2'd0;
      warn_q <= 1'b0;
    end else if (clr) begin
      done_q <= 1'b0;
      ok_q   <= 1'b0;
      err_q  <= 2'd0;
      warn_q <= 1'b0;
    end else begin
      if (fin_set) begin
        done_q <= 1'b1;
        ok_q   <= fin_ok;
        err_q  <= fin_err;
      end
      if (warn_load) warn_q <= warn_val;
    end
  end

endmodule

// File: rtl/sd_pwr_seq.sv
module sd_pwr_seq
  import sd_pwr_pkg::*;
#(
  parameter int CLK_FREQ_HZ = 100_000_000,
  parameter int SETTLE_NS   = 1000,
  parameter int PWRUP_US    = 1000,
  parameter int PWROFF_US   = 500_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       sw_fitted,
  input  logic       sclk_in,
  input  logic       cmd_in,
  input  logic [3:0] dat_in,
  input  logic       det_in,
  output logic       sclk_run_en,
  output logic       sclk_drv_lo,
  output logic       cmd_drv_lo,
  output logic [3:0] dat_drv_lo,
  output logic       pwr_off,
  output logic       done,
  output logic       ok,
  output logic [1:0] err_code,
  output logic       warn
);

  localparam int CYC_PER_US = CLK_FREQ_HZ / 1_000_000;
  localparam int S_RAW      = (CYC_PER_US * SETTLE_NS) / 1000;
  localparam int W_RAW      = CYC_PER_US * PWRUP_US;
  localparam int P_RAW      = CYC_PER_US * PWROFF_US;
  localparam int S_CYC      = (S_RAW < 1) ? 1 : S_RAW;
  localparam int W_CYC      = (W_RAW < 1) ? 1 : W_RAW;
  localparam int P_CYC      = (P_RAW < 1) ? 1 : P_RAW;
  localparam int MAX_SW     = (S_CYC > W_CYC) ? S_CYC : W_CYC;
  localparam int MAX_CYC    = (MAX_SW > P_CYC) ? MAX_SW : P_CYC;
  localparam int CW         = $clog2(MAX_CYC + 1);

  logic rst_meta_q;
  logic rst_sync_q;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  seq_state_e    state_q;
  logic          pass2_q;
  logic          tmr_load;
  logic [CW-1:0] tmr_val;
  logic          tmr_zero;
  logic          accept;
  logic          fin_set;
  logic          fin_ok;
  seq_err_e      fin_err;
  logic          warn_load;
  pin_ctl_t      pins;

  sd_pwr_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  sd_pwr_fsm #(
    .CW    (CW),
    .S_CYC (S_CYC),
    .P_CYC (P_CYC),
    .W_CYC (W_CYC)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .start     (start),
    .sw_fitted (sw_fitted),
    .cmd_in    (cmd_in),
    .dat_in    (dat_in),
    .det_in    (det_in),
    .tmr_zero  (tmr_zero),
    .state_q   (state_q),
    .pass2_q   (pass2_q),
    .tmr_load  (tmr_load),
    .tmr_val   (tmr_val),
    .accept    (accept),
    .fin_set   (fin_set),
    .fin_ok    (fin_ok),
    .fin_err   (fin_err),
    .warn_load (warn_load)
  );

  sd_pwr_pins u_pins (
    .state_q (state_q),
    .pass2_q (pass2_q),
    .pins    (pins)
  );

  sd_pwr_status u_status (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .clr       (accept),
    .fin_set   (fin_set),
    .fin_ok    (fin_ok),
    .fin_err   (fin_err),
    .warn_load (warn_load),
    .warn_val  (sclk_in),
    .done_q    (done),
    .ok_q      (ok),
    .err_q     (err_code),
    .warn_q    (warn)
  );

  assign sclk_run_en = pins.run_en;
  assign sclk_drv_lo = pins.clk_lo;
  assign cmd_drv_lo  = pins.cmd_lo;
  assign dat_drv_lo  = pins.dat_lo;
  assign pwr_off     = pins.pwr_off;

endmodule

// File: rtl/sd_pwr_seq_chk.sv
module sd_pwr_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       sclk_run_en,
  input logic       sclk_drv_lo,
  input logic       cmd_drv_lo,
  input logic [3:0] dat_drv_lo,
  input logic       pwr_off,
  input logic       done,
  input logic       ok,
  input logic [1:0] err_code,
  input logic       warn
);

  assert_gate_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk_run_en) |-> (!sclk_drv_lo && !cmd_drv_lo && dat_drv_lo == 4'b0 && !pwr_off));

  assert_ok_matches_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ok == (err_code == 2'd0)));

  assert_code_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    err_code != 2'd3);

  assert_discharge_before_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_off) |-> ($past(sclk_drv_lo && cmd_drv_lo && (&dat_drv_lo))
                        && sclk_drv_lo && cmd_drv_lo && (&dat_drv_lo)));

  assert_off_while_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_off |-> !sclk_run_en);

  assert_power_released_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_off) |-> (!sclk_drv_lo && !cmd_drv_lo && dat_drv_lo == 4'b0));

  assert_clk_after_lines_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_off && $fell(sclk_drv_lo)) |-> (!cmd_drv_lo && dat_drv_lo == 4'b0 && $past(!cmd_drv_lo)));

  assert_done_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> sclk_run_en);

  assert_status_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> $stable({done, ok, err_code, warn}));

endmodule

bind sd_pwr_seq sd_pwr_seq_chk chk_i (.*);

// File: tb/sd_pwr_seq_tb_top.sv
module sd_pwr_seq_tb_top;

  localparam int FREQ = 100_000_000;
  localparam int SNS  = 50;
  localparam int WUS  = 1;
  localparam int PUS  = 20;
  localparam int CPU  = FREQ / 1_000_000;
  localparam int S    = (CPU * SNS) / 1000;
  localparam int W    = CPU * WUS;
  localparam int P    = CPU * PUS;
  localparam int T_SHORT = 4 * S + 4;
  localparam int T_FULL  = 6 * S + P + W + 7;

  logic       clk;
  logic       rst_n;
  logic       start;
  logic       sw_fitted;
  logic       sclk_in;
  logic       cmd_in;
  logic [3:0] dat_in;
  logic       det_in;
  logic       sclk_run_en;
  logic       sclk_drv_lo;
  logic       cmd_drv_lo;
  logic [3:0] dat_drv_lo;
  logic       pwr_off;
  logic       done;
  logic       ok;
  logic [1:0] err_code;
  logic       warn;

  int  checks = 0;
  int  failures = 0;
  int  cyc = 0;
  int  off_age = 0;
  logic stuck = 1'b0;

  sd_pwr_seq #(
    .CLK_FREQ_HZ (FREQ),
    .SETTLE_NS   (SNS),
    .PWRUP_US    (WUS),
    .PWROFF_US   (PUS)
  ) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .sw_fitted   (sw_fitted),
    .sclk_in     (sclk_in),
    .cmd_in      (cmd_in),
    .dat_in      (dat_in),
    .det_in      (det_in),
    .sclk_run_en (sclk_run_en),
    .sclk_drv_lo (sclk_drv_lo),
    .cmd_drv_lo  (cmd_drv_lo),
    .dat_drv_lo  (dat_drv_lo),
    .pwr_off     (pwr_off),
    .done        (done),
    .ok          (ok),
    .err_code    (err_code),
    .warn        (warn)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Card supply model: decays a few cycles after power removal unless stuck.
  always @(posedge clk) begin
    if (pwr_off) off_age <= off_age + 1;
    else         off_age <= 0;
  end
  assign sclk_in = stuck | ~pwr_off | (off_age < 5);

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc > 150000) begin
      failures = failures + 1;
      $display("FAIL watchdog expired after %0d cycles (expected completion)", cyc);
      finish_run();
    end
  end

  task automatic chk(input bit cond, input string what, input int act, input int exp);
    checks = checks + 1;
    if (!cond) begin
      failures = failures + 1;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // Expected {run_en, pwr_off, clk_lo, cmd_lo, dat_lo[3:0]} at cycle n of a run.
  function automatic logic [7:0] exp_pins(input int n, input bit full);
    logic gate, pw, ck, cm;
    logic [3:0] dt;
    int a;
    gate = 1'b0; pw = 1'b0; ck = 1'b0; cm = 1'b0; dt = 4'h0;
    a = 4 * S + 4;
    if (n >= 2 * S + 3 && n <= 3 * S + 2) begin cm = 1'b1; dt = 4'hF; end
    if (full) begin
      if (n == a) begin ck = 1'b1; cm = 1'b1; dt = 4'hF; end
      if (n >= a + 1 && n <= a + P + 1) begin ck = 1'b1; cm = 1'b1; dt = 4'hF; pw = 1'b1; end
      if (n >= a + P + 2 && n <= a + P + S + 1) begin ck = 1'b1; pw = 1'b1; end
      if (n == a + P + S + 2) pw = 1'b1;
    end
    return {gate, pw, ck, cm, dt};
  endfunction

  task automatic run_seq(input bit sw, input bit det, input bit cmdv, input logic [3:0] datv,
                         input bit stk, input int pulse_at, input bit full,
                         input bit eok, input int eerr, input bit ewarn, input string tag);
    int t;
    int n;
    int bad;
    int bad_n;
    logic [7:0] act;
    logic [7:0] bad_act;
    logic [7:0] bad_exp;
    bit early;
    t = full ? T_FULL : T_SHORT;
    sw_fitted = sw; det_in = det; cmd_in = cmdv; dat_in = datv; stuck = stk;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b0, {tag, " R10 done cleared after start"}, done, 0);
    n = 1; bad = 0; bad_n = 0; early = 1'b0; bad_act = '0; bad_exp = '0;
    while (n < t) begin
      act = {sclk_run_en, pwr_off, sclk_drv_lo, cmd_drv_lo, dat_drv_lo};
      if (act != exp_pins(n, full)) begin
        if (bad == 0) begin bad_n = n; bad_act = act; bad_exp = exp_pins(n, full); end
        bad = bad + 1;
      end
      if (done) early = 1'b1;
      if (n == pulse_at) start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      n = n + 1;
    end
    if (bad != 0)
      $display("FAIL %s R2/R5/R6 pin mismatch at cycle %0d actual=%0h expected=%0h",
               tag, bad_n, bad_act, bad_exp);
    checks = checks + 1;
    if (bad != 0) failures = failures + 1;
    chk(!early, {tag, " R11 done not before computed length"}, early, 0);
    chk(done == 1'b1, {tag, " R7/R11 done at computed cycle"}, done, 1);
    chk(ok == eok, {tag, " R3/R4/R7 ok"}, ok, eok);
    chk(int'(err_code) == eerr, {tag, " R3/R4 err_code"}, err_code, eerr);
    chk(warn == ewarn, {tag, " R8 warn"}, warn, ewarn);
    chk(sclk_run_en == 1'b1 && pwr_off == 1'b0, {tag, " R7 idle pins after done"},
        {sclk_run_en, pwr_off}, 2);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; sw_fitted = 1'b0; cmd_in = 1'b1; dat_in = 4'hF; det_in = 1'b0;
    repeat (3) @(negedge clk);
    chk({sclk_run_en, pwr_off, sclk_drv_lo, cmd_drv_lo, dat_drv_lo} == 8'h80,
        "R1 pins in reset", {sclk_run_en, pwr_off, sclk_drv_lo, cmd_drv_lo, dat_drv_lo}, 8'h80);
    chk({done, ok, err_code, warn} == 5'b0, "R1 status in reset", {done, ok, err_code, warn}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({sclk_run_en, pwr_off, sclk_drv_lo, cmd_drv_lo, dat_drv_lo} == 8'h80,
        "R1 pins after reset", {sclk_run_en, pwr_off, sclk_drv_lo, cmd_drv_lo, dat_drv_lo}, 8'h80);
    chk(done == 1'b0, "R1 done after reset", done, 0);

    // R3: every CMD/DAT level without a switch; detect input toggled to show it is ignored.
    for (int c = 0; c < 2; c++) begin
      for (int d = 0; d < 16; d++) begin
        bit good;
        good = (c == 1) && (d == 15);
        run_seq(1'b0, d[0], c[0], d[3:0], 1'b1, -1, 1'b0, good, good ? 0 : 1, 1'b0, "noswitch_R3");
      end
    end

    // R4: switch fitted, no card, with assorted line levels.
    for (int d = 0; d < 16; d++) begin
      run_seq(1'b1, 1'b1, d[1], d[3:0], 1'b0, -1, 1'b0, 1'b0, 2, 1'b0, "nocard_R4");
    end

    // R8: stuck-high supply raises a warning, run still ok.
    run_seq(1'b1, 1'b0, 1'b1, 4'hF, 1'b1, -1, 1'b1, 1'b1, 0, 1'b1, "stuck_R8");
    // R5/R6/R7: normal cycle, warning cleared.
    run_seq(1'b1, 1'b0, 1'b1, 4'hF, 1'b0, -1, 1'b1, 1'b1, 0, 1'b0, "cycle_R7");
    // Line levels do not matter once a switch is fitted and a card is present.
    run_seq(1'b1, 1'b0, 1'b0, 4'h3, 1'b0, -1, 1'b1, 1'b1, 0, 1'b0, "cycle_lines_R5");
    // R9: start pulses during a run are ignored.
    run_seq(1'b1, 1'b0, 1'b1, 4'hF, 1'b0, 30, 1'b1, 1'b1, 0, 1'b0, "busy_start_R9");
    run_seq(1'b1, 1'b0, 1'b1, 4'hF, 1'b0, T_SHORT + 40, 1'b1, 1'b1, 0, 1'b0, "busy_off_R9");
    run_seq(1'b0, 1'b0, 1'b0, 4'hF, 1'b0, 10, 1'b0, 1'b0, 1, 1'b0, "busy_short_R9");

    // R10: status holds while inputs change and no start arrives.
    sw_fitted = 1'b1; det_in = 1'b1; cmd_in = 1'b1; dat_in = 4'hF;
    repeat (50) @(negedge clk);
    chk({done, ok, err_code, warn} == 5'b10010, "R10 status held between runs",
        {done, ok, err_code, warn}, 5'b10010);
    chk(pwr_off == 1'b0 && sclk_run_en == 1'b1, "R10 idle pins held", {pwr_off, sclk_run_en}, 1);

    finish_run();
  end

endmodule